// File: doc/BRIEF.md
# Dual-Depth Disk Address Register File

This block holds the parameter bytes a host loads before it issues a disk command: three address bytes (low, mid, high) and a sector count. Each of the four registers is two slots deep. A host write pushes the byte already held into a "previous" slot and stores the new byte as "latest". Because of this, two writes in a row to the same register provide both halves of a 48-bit block address or a 16-bit count. A single write per register is enough for the 28-bit form.

The command engine reads a fully assembled address and an effective transfer length. A mode input selects 28-bit or 48-bit decoding. A count of zero is turned into the largest length the selected mode allows. When a command finishes, the engine pulses a write-back strobe with the address it reached and the sectors still outstanding. Both slots of every register are reloaded from these values, so that the host sees the final state when it reads the registers back. In 28-bit mode the top four address bits come from a device/head nibble held outside this block.

Top module: `lbaParamRegs`

## Requirements
- R1: After reset every slot holds zero, so with 28-bit mode and a zero device/head nibble the address output is 0 and the count output is 256.
- R2: A host write with select 0 (count), 1 (low), 2 (mid) or 3 (high) moves that register's latest byte into its previous slot and stores the written byte as latest. The other three registers do not change.
- R3: The read data is combinational. It returns the selected register's latest byte when the history select is 0 and its previous byte when the history select is 1.
- R4: In 48-bit mode the address is {prev high, prev mid, prev low, high, mid, low}, with the low latest byte in bits 7:0 and the high previous byte in bits 47:40.
- R5: In 28-bit mode the address is {20 zero bits, device/head nibble, high, mid, low}. The previous slots are not used.
- R6: In 28-bit mode the count output equals the latest count byte, and a zero byte yields 256.
- R7: In 48-bit mode the count output is {prev count, count}, and a zero value yields 65536.
- R8: On an edge where the completion strobe is high, the latest slots load done address bits 7:0, 15:8 and 23:16 and remaining-count bits 7:0. The previous slots load address bits 31:24, 39:32 and 47:40 and count bits 15:8. This happens in either mode.
- R9: When the completion strobe and a host write arrive on the same edge, the completion load wins and the host write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 2 | Register select: 0 count, 1 low, 2 mid, 3 high |
| hostHist | input | 1 | Read history select: 0 latest, 1 previous |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte |
| extMode | input | 1 | 1 selects 48-bit decoding, 0 selects 28-bit |
| devHead | input | 4 | Address bits 27:24 in 28-bit mode |
| cmdLba | output | 48 | Assembled block address |
| cmdCount | output | 17 | Effective sector count |
| doneValid | input | 1 | Completion write-back strobe |
| doneLba | input | 48 | Final address reached |
| doneRemain | input | 16 | Sectors still outstanding |

## Verification
The assertions assume that the mode, device/head nibble and read select are levels that the command engine keeps steady around an edge. The write-back check only applies the 48-bit view when the mode is set on the cycle after the load. The bench changes these inputs only between edges. It mixes random write streams and random completions, including completions that land on the same edge as a host write, with directed zero-count cases in both modes.

// File: rtl/lbaRegPkg.sv
package lbaRegPkg;
  localparam int BYTE_W  = 8;
  localparam int REG_CNT = 4;
  localparam int SEL_W   = $clog2(REG_CNT);
  localparam int HEAD_W  = 4;
  localparam int ADDR_BYTES = 3;
  localparam int LBA_W   = 2 * ADDR_BYTES * BYTE_W;
  localparam int REM_W   = 2 * BYTE_W;
  localparam int CNT_W   = REM_W + 1;
  localparam int IDX_CNT  = 0;
  localparam int IDX_LOW  = 1;
  localparam int IDX_MID  = 2;
  localparam int IDX_HIGH = 3;

  typedef struct packed {
    logic [REG_CNT-1:0] shiftEn;
    logic               loadAll;
  } slotCtrlT;
endpackage

// File: rtl/lbaRegCtrl.sv
module lbaRegCtrl
  import lbaRegPkg::*;
(
  input  logic             hostWrEn,
  input  logic [SEL_W-1:0] hostSel,
  input  logic             doneValid,
  output slotCtrlT         strobe
);
  always_comb begin
    strobe = '0;
    strobe.loadAll = doneValid;
    if (hostWrEn && !doneValid) begin
      strobe.shiftEn[hostSel] = 1'b1;
    end
  end
endmodule

// File: rtl/lbaRegPath.sv
module lbaRegPath
  import lbaRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  slotCtrlT          strobe,
  input  logic [BYTE_W-1:0] hostWrData,
  input  logic [SEL_W-1:0]  hostSel,
  input  logic              hostHist,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic              extMode,
  input  logic [HEAD_W-1:0] devHead,
  input  logic [LBA_W-1:0]  doneLba,
  input  logic [REM_W-1:0]  doneRemain,
  output logic [LBA_W-1:0]  cmdLba,
  output logic [CNT_W-1:0]  cmdCount
);
  localparam int LOW_W = ADDR_BYTES * BYTE_W;
  localparam int PAD_W = LBA_W - LOW_W - HEAD_W;

  logic [BYTE_W-1:0] latest [REG_CNT];
  logic [BYTE_W-1:0] prev   [REG_CNT];
  logic [BYTE_W-1:0] loadLat [REG_CNT];
  logic [BYTE_W-1:0] loadPrv [REG_CNT];

  assign loadLat[IDX_CNT] = doneRemain[BYTE_W-1:0];
  assign loadPrv[IDX_CNT] = doneRemain[2*BYTE_W-1:BYTE_W];

  for (genvar a = 0; a < ADDR_BYTES; a++) begin : g_addrMap
    assign loadLat[IDX_LOW + a] = doneLba[a*BYTE_W +: BYTE_W];
    assign loadPrv[IDX_LOW + a] = doneLba[(a+ADDR_BYTES)*BYTE_W +: BYTE_W];
  end

  for (genvar k = 0; k < REG_CNT; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        latest[k] <= '0;
        prev[k]   <= '0;
      end else if (strobe.loadAll) begin
        latest[k] <= loadLat[k];
        prev[k]   <= loadPrv[k];
      end else if (strobe.shiftEn[k]) begin
        prev[k]   <= latest[k];
        latest[k] <= hostWrData;
      end
    end

    // R2
    shift_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.shiftEn[k] |=> (latest[k] == $past(hostWrData)) && (prev[k] == $past(latest[k])));

    // R8
    load_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.loadAll |=> (latest[k] == $past(loadLat[k])) && (prev[k] == $past(loadPrv[k])));
  end

  assign hostRdData = hostHist ? prev[hostSel] : latest[hostSel];

  logic [LOW_W-1:0] lowAddr, highAddr;
  logic [REM_W-1:0] wideCnt;

  always_comb begin
    lowAddr  = {latest[IDX_HIGH], latest[IDX_MID], latest[IDX_LOW]};
    highAddr = {prev[IDX_HIGH], prev[IDX_MID], prev[IDX_LOW]};
    wideCnt  = {prev[IDX_CNT], latest[IDX_CNT]};
    if (extMode) begin
      cmdLba   = {highAddr, lowAddr};
      cmdCount = (wideCnt == '0) ? CNT_W'(1 << REM_W) : CNT_W'(wideCnt);
    end else begin
      cmdLba   = {{PAD_W{1'b0}}, devHead, lowAddr};
      cmdCount = (latest[IDX_CNT] == '0) ? CNT_W'(1 << BYTE_W) : CNT_W'(latest[IDX_CNT]);
    end
  end

  // R6
  short_count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extMode |-> (cmdCount != '0) && (cmdCount <= CNT_W'(1 << BYTE_W)));

  // R7
  wide_count_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    extMode |-> (cmdCount != '0));

  // R5
  short_addr_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    !extMode |-> (cmdLba[LBA_W-1:LOW_W+HEAD_W] == '0));
endmodule

// File: rtl/lbaParamRegs.sv
module lbaParamRegs
  import lbaRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [SEL_W-1:0]  hostSel,
  input  logic              hostHist,
  input  logic [BYTE_W-1:0] hostWrData,
  output logic [BYTE_W-1:0] hostRdData,
  input  logic              extMode,
  input  logic [HEAD_W-1:0] devHead,
  output logic [LBA_W-1:0]  cmdLba,
  output logic [CNT_W-1:0]  cmdCount,
  input  logic              doneValid,
  input  logic [LBA_W-1:0]  doneLba,
  input  logic [REM_W-1:0]  doneRemain
);
  slotCtrlT strobe;

  lbaRegCtrl u_ctrl (
    .hostWrEn (hostWrEn),
    .hostSel  (hostSel),
    .doneValid(doneValid),
    .strobe   (strobe)
  );

  lbaRegPath u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWrData(hostWrData),
    .hostSel   (hostSel),
    .hostHist  (hostHist),
    .hostRdData(hostRdData),
    .extMode   (extMode),
    .devHead   (devHead),
    .doneLba   (doneLba),
    .doneRemain(doneRemain),
    .cmdLba    (cmdLba),
    .cmdCount  (cmdCount)
  );

  // R9
  done_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && hostWrEn) |=> (!extMode || (cmdLba == $past(doneLba))));
endmodule

// File: tb/lbaParamRegs_tb.sv
`timescale 1ns/100ps
module lbaParamRegs_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        hostWrEn;
  logic [1:0]  hostSel;
  logic        hostHist;
  logic [7:0]  hostWrData;
  logic [7:0]  hostRdData;
  logic        extMode;
  logic [3:0]  devHead;
  logic [47:0] cmdLba;
  logic [16:0] cmdCount;
  logic        doneValid;
  logic [47:0] doneLba;
  logic [15:0] doneRemain;

  int checks = 0;
  int errors = 0;
  logic [7:0] mLat [4];
  logic [7:0] mPrv [4];

  always #4 clk = ~clk;

  lbaParamRegs u_dut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostHist(hostHist), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .extMode(extMode), .devHead(devHead), .cmdLba(cmdLba), .cmdCount(cmdCount),
    .doneValid(doneValid), .doneLba(doneLba), .doneRemain(doneRemain)
  );

  function automatic logic [47:0] expLba(input logic m, input logic [3:0] dh);
    if (m) return {mPrv[3], mPrv[2], mPrv[1], mLat[3], mLat[2], mLat[1]};
    return {20'h0, dh, mLat[3], mLat[2], mLat[1]};
  endfunction

  function automatic logic [16:0] expCnt(input logic m);
    logic [15:0] w;
    if (m) begin
      w = {mPrv[0], mLat[0]};
      return (w == 16'h0) ? 17'd65536 : {1'b0, w};
    end
    return (mLat[0] == 8'h0) ? 17'd256 : {9'h0, mLat[0]};
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    chk(cmdLba === expLba(extMode, devHead), {tag, " lba (R4/R5)"}, cmdLba, expLba(extMode, devHead));
    chk(cmdCount === expCnt(extMode), {tag, extMode ? " count R7" : " count R6"},
        {31'h0, cmdCount}, {31'h0, expCnt(extMode)});
    chk(hostRdData === (hostHist ? mPrv[hostSel] : mLat[hostSel]), {tag, " readback R3"},
        {40'h0, hostRdData}, {40'h0, hostHist ? mPrv[hostSel] : mLat[hostSel]});
  endtask

  task automatic step(input logic wr, input logic [1:0] sel, input logic [7:0] d,
                      input logic dn, input logic [47:0] dl, input logic [15:0] dr,
                      input logic m, input logic [3:0] dh, input string tag);
    @(negedge clk);
    hostWrEn = wr; hostSel = sel; hostWrData = d;
    doneValid = dn; doneLba = dl; doneRemain = dr;
    @(posedge clk);
    if (dn) begin
      mLat[0] = dr[7:0];   mPrv[0] = dr[15:8];
      mLat[1] = dl[7:0];   mPrv[1] = dl[31:24];
      mLat[2] = dl[15:8];  mPrv[2] = dl[39:32];
      mLat[3] = dl[23:16]; mPrv[3] = dl[47:40];
    end else if (wr) begin
      mPrv[sel] = mLat[sel];
      mLat[sel] = d;
    end
    #1;
    hostWrEn = 1'b0; doneValid = 1'b0;
    extMode = m; devHead = dh;
    hostSel = 2'($urandom_range(0, 3)); hostHist = 1'($urandom_range(0, 1));
    #1;
    checkOutputs(tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; hostWrEn = 0; hostSel = 0; hostHist = 0; hostWrData = 0;
    extMode = 0; devHead = 0; doneValid = 0; doneLba = 0; doneRemain = 0;
    for (int i = 0; i < 4; i++) begin mLat[i] = 8'h0; mPrv[i] = 8'h0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // R1: reset state
    chk(cmdLba === 48'h0, "R1 reset lba", cmdLba, 48'h0);
    chk(cmdCount === 17'd256, "R1 reset count", {31'h0, cmdCount}, 48'd256);
    for (int s = 0; s < 8; s++) begin
      hostSel = 2'(s); hostHist = 1'(s >> 2);
      #0.5;
      chk(hostRdData === 8'h0, "R1 reset slot", {40'h0, hostRdData}, 48'h0);
    end
    extMode = 1'b1; #0.5;
    chk(cmdCount === 17'd65536, "R7 zero count wide", {31'h0, cmdCount}, 48'd65536);

    // R2/R4: directed 48-bit address build
    step(1, 1, 8'h44, 0, 0, 0, 1, 4'h0, "R2 low first");
    step(1, 1, 8'h11, 0, 0, 0, 1, 4'h0, "R2 low second");
    step(1, 2, 8'h55, 0, 0, 0, 1, 4'h0, "R2 mid first");
    step(1, 2, 8'h22, 0, 0, 0, 1, 4'h0, "R2 mid second");
    step(1, 3, 8'h66, 0, 0, 0, 1, 4'h0, "R2 high first");
    step(1, 3, 8'h33, 0, 0, 0, 1, 4'h0, "R2 high second");
    chk(cmdLba === 48'h665544332211, "R4 wide address", cmdLba, 48'h665544332211);

    // R5: 28-bit view with head nibble
    step(0, 0, 0, 0, 0, 0, 0, 4'hA, "R5 short mode");
    chk(cmdLba === 48'h00000A332211, "R5 short address", cmdLba, 48'h00000A332211);

    // R6/R7: zero low count byte with non-zero previous
    step(1, 0, 8'h01, 0, 0, 0, 0, 4'h0, "R2 count first");
    step(1, 0, 8'h00, 0, 0, 0, 0, 4'h0, "R6 count zero");
    chk(cmdCount === 17'd256, "R6 zero count short", {31'h0, cmdCount}, 48'd256);
    step(0, 0, 0, 0, 0, 0, 1, 4'h0, "R7 count 0x100");
    chk(cmdCount === 17'd256, "R7 wide 0x0100", {31'h0, cmdCount}, 48'd256);

    // R8: completion load in short mode, checked through wide view next
    step(0, 0, 0, 1, 48'hA1B2C3D4E5F6, 16'h0000, 0, 4'h0, "R8 load");
    step(0, 0, 0, 0, 0, 0, 1, 4'h0, "R8 view");
    chk(cmdLba === 48'hA1B2C3D4E5F6, "R8 loaded address", cmdLba, 48'hA1B2C3D4E5F6);
    chk(cmdCount === 17'd65536, "R8 zero remain", {31'h0, cmdCount}, 48'd65536);

    // R9: completion and host write on the same edge
    step(1, 1, 8'hEE, 1, 48'h0102030405FF, 16'h1234, 1, 4'h0, "R9 collide");
    chk(cmdLba === 48'h0102030405FF, "R9 write dropped", cmdLba, 48'h0102030405FF);
    chk(cmdCount === 17'h1234, "R9 remain count", {31'h0, cmdCount}, 48'h1234);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic dn, wr;
      dn = ($urandom_range(0, 9) == 0);
      wr = ($urandom_range(0, 3) != 0);
      step(wr, 2'($urandom_range(0, 3)),
           ($urandom_range(0, 7) == 0) ? 8'h00 : 8'($urandom),
           dn, {16'($urandom), 32'($urandom)},
           ($urandom_range(0, 3) == 0) ? 16'h0 : 16'($urandom),
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), "random R2/R8/R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule